// File: doc/BRIEF.md
# Bus Parity Checker and Error Reporter

This block watches a 32-bit multiplexed address/data bus with four active-low byte-enable lines on a bridge that can act as either initiator or target. The parity bit for a given clock arrives one clock later. So the block stores the bus contents of each clock and checks them against the parity bit it sees on the next clock. Parity is even across the address/data lines, the byte enables and the parity bit together. Checks are made on the first clock of a frame (the address phase) and on every data phase that completes.

When a check fails, the block does several things. It raises an address-parity veto so that target decode does not claim the cycle. It requests a master abort when the bridge is the initiator of a read. It drives an active-low system-error line or an active-low parity-error line. Each of those lines has its own output enable and goes through a fixed sequence: driven low, then driven high, then released. Two command bits gate the reporting: one for parity response and one for system-error enable. Two sticky flags record that a parity error was detected and that a system error was signalled. A clear input resets both flags.

Top module: `bus_parity_mon`

## Requirements
- R1: Parity is even over ad[31:0], cbe_n[3:0] and par, where par is taken one clock after the bus contents it covers. When the first clock of a frame (frame_n low, and high on the previous clock) has bad parity, addr_perr is high during the following clock, the clock in which par is presented. This does not depend on the command bits.
- R2: A data phase is checked only on a clock where both irdy_n and trdy_n are low and that clock is not the first clock of a frame. Wait-state clocks with bad parity cause no error of any kind.
- R3: An address parity error found in clock T+1 drives serr_n_o low with serr_oe high for exactly clock T+2. This happens only if cmd_perr_en and cmd_serr_en are both 1 during clock T+1.
- R4: After its last low clock, each error line is driven high with its enable still set for one clock. The enable is 0 from the next clock onwards.
- R5: A reportable data parity error found in clock D+1 drives perr_n_o low with perr_oe high during clock D+2. This happens only if cmd_perr_en is 1 during clock D+1.
- R6: A data error is reportable only when the bridge is target on a write (is_master=0, is_read=0) or initiator on a read (is_master=1, is_read=1). Both is_master and is_read are taken from the data-phase clock.
- R7: A data parity error on a phase where is_master=1 and is_read=1 raises mabort_req during the following clock, whatever the command bits are.
- R8: Data errors on consecutive completed phases keep perr_n_o low for consecutive clocks, with no high clock between them.
- R9: det_perr sets on any checked parity error, and sig_serr sets whenever system-error is asserted. Both are visible in the clock after detection. flag_clr clears both flags on the next clock. A set in the same clock as a clear wins.
- R10: While rst_n is low, both enables, both flags, addr_perr and mabort_req are 0, and both error lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command / byte-enable lines |
| par | input | 1 | Even parity for the previous clock's ad and cbe_n |
| frame_n | input | 1 | Active-low frame strobe |
| irdy_n | input | 1 | Active-low initiator ready |
| trdy_n | input | 1 | Active-low target ready |
| is_master | input | 1 | 1 when the bridge initiates the current transaction |
| is_read | input | 1 | 1 when the current transaction is a read |
| cmd_perr_en | input | 1 | Parity-response command bit |
| cmd_serr_en | input | 1 | System-error enable command bit |
| flag_clr | input | 1 | Clears the sticky flags |
| serr_n_o | output | 1 | Active-low system-error value |
| serr_oe | output | 1 | Output enable for serr_n_o |
| perr_n_o | output | 1 | Active-low parity-error value |
| perr_oe | output | 1 | Output enable for perr_n_o |
| addr_perr | output | 1 | Address parity veto for target decode |
| mabort_req | output | 1 | Master-abort request on a read data parity error |
| det_perr | output | 1 | Sticky detected-parity-error flag |
| sig_serr | output | 1 | Sticky signalled-system-error flag |

## Verification
Two functions can meet in one clock. The first is setting and clearing the sticky flags. The bench asserts flag_clr in exactly the clock in which a bad data phase's parity bit is checked, and expects det_perr to stay set. The second is the two reporting lines. An address parity error followed directly by a bad data phase puts the system-error release sequence and the parity-error low pulse into adjacent, overlapping windows, and the bench checks each line's value and enable on every clock against a model built from the timing offsets.

// File: rtl/bus_parity_mon.sv
module bus_parity_mon #(
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ad,
  input  logic [BW-1:0] cbe_n,
  input  logic          par,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          trdy_n,
  input  logic          is_master,
  input  logic          is_read,
  input  logic          cmd_perr_en,
  input  logic          cmd_serr_en,
  input  logic          flag_clr,
  output logic          serr_n_o,
  output logic          serr_oe,
  output logic          perr_n_o,
  output logic          perr_oe,
  output logic          addr_perr,
  output logic          mabort_req,
  output logic          det_perr,
  output logic          sig_serr
);

  logic [DW-1:0] ad_q;
  logic [BW-1:0] cbe_q;
  logic frm_q, addr_v, data_v, rpt_q, mrd_q;
  logic serr_lo, serr_hi, perr_lo, perr_hi, det_q, sig_q;

  logic first_clk, done, bad, a_err, d_err, serr_set, perr_set;

  assign first_clk = !frame_n && frm_q;
  assign done      = !irdy_n && !trdy_n;
  assign bad       = ^{ad_q, cbe_q, par};
  assign a_err     = addr_v && bad;
  assign d_err     = data_v && bad;
  assign serr_set  = a_err && cmd_perr_en && cmd_serr_en;
  assign perr_set  = d_err && rpt_q && cmd_perr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ad_q    <= '0;
      cbe_q   <= '0;
      frm_q   <= 1'b1;
      addr_v  <= 1'b0;
      data_v  <= 1'b0;
      rpt_q   <= 1'b0;
      mrd_q   <= 1'b0;
      serr_lo <= 1'b0;
      serr_hi <= 1'b0;
      perr_lo <= 1'b0;
      perr_hi <= 1'b0;
      det_q   <= 1'b0;
      sig_q   <= 1'b0;
    end else begin
      ad_q    <= ad;
      cbe_q   <= cbe_n;
      frm_q   <= frame_n;
      addr_v  <= first_clk;
      data_v  <= done && !first_clk;
      rpt_q   <= (is_master == is_read);
      mrd_q   <= is_master && is_read;
      serr_lo <= serr_set;
      serr_hi <= serr_lo && !serr_set;
      perr_lo <= perr_set;
      perr_hi <= perr_lo && !perr_set;
      if (a_err || d_err) det_q <= 1'b1;
      else if (flag_clr)  det_q <= 1'b0;
      if (serr_set)       sig_q <= 1'b1;
      else if (flag_clr)  sig_q <= 1'b0;
    end
  end

  assign serr_n_o   = !serr_lo;
  assign serr_oe    = serr_lo || serr_hi;
  assign perr_n_o   = !perr_lo;
  assign perr_oe    = perr_lo || perr_hi;
  assign addr_perr  = a_err;
  assign mabort_req = d_err && mrd_q;
  assign det_perr   = det_q;
  assign sig_serr   = sig_q;

endmodule

// File: rtl/bus_parity_mon_sva.sv
module bus_parity_mon_sva (
  input logic clk,
  input logic rst_n,
  input logic cmd_perr_en,
  input logic cmd_serr_en,
  input logic flag_clr,
  input logic serr_n_o,
  input logic serr_oe,
  input logic perr_n_o,
  input logic perr_oe,
  input logic addr_perr,
  input logic mabort_req,
  input logic det_perr,
  input logic sig_serr
);

  p_serr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_oe && !serr_n_o) |-> $past(cmd_perr_en && cmd_serr_en));

  p_serr_from_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_oe && !serr_n_o) |-> $past(addr_perr));

  p_serr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_oe && !serr_n_o) |=> serr_oe);

  p_serr_high_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_oe && serr_n_o) |=> (!serr_oe || !serr_n_o));

  p_perr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_o) |-> $past(cmd_perr_en));

  p_perr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_o) |=> perr_oe);

  p_perr_high_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_o) |=> (!perr_oe || !perr_n_o));

  p_mabort_not_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mabort_req |-> !addr_perr);

  p_mabort_reports_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mabort_req && cmd_perr_en) |=> (perr_oe && !perr_n_o));

  p_det_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_perr) |-> $past(flag_clr));

  p_sig_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_serr) |-> $past(flag_clr));

  p_sig_with_det_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_serr) |-> det_perr);

endmodule

bind bus_parity_mon bus_parity_mon_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_perr_en(cmd_perr_en), .cmd_serr_en(cmd_serr_en),
  .flag_clr(flag_clr), .serr_n_o(serr_n_o), .serr_oe(serr_oe), .perr_n_o(perr_n_o),
  .perr_oe(perr_oe), .addr_perr(addr_perr), .mabort_req(mabort_req),
  .det_perr(det_perr), .sig_serr(sig_serr)
);

// File: tb/test_bus_parity_mon.sv
module test_bus_parity_mon;
  localparam int DW = 32;
  localparam int BW = 4;
  localparam int HN = 4096;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DW-1:0] ad = '0;
  logic [BW-1:0] cbe_n = '1;
  logic par = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic is_master = 1'b0, is_read = 1'b0;
  logic cmd_perr_en = 1'b0, cmd_serr_en = 1'b0, flag_clr = 1'b0;
  logic serr_n_o, serr_oe, perr_n_o, perr_oe, addr_perr, mabort_req, det_perr, sig_serr;

  bus_parity_mon #(.DW(DW), .BW(BW)) i_bus_parity_mon (
    .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .par(par),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .is_master(is_master), .is_read(is_read),
    .cmd_perr_en(cmd_perr_en), .cmd_serr_en(cmd_serr_en), .flag_clr(flag_clr),
    .serr_n_o(serr_n_o), .serr_oe(serr_oe), .perr_n_o(perr_n_o), .perr_oe(perr_oe),
    .addr_perr(addr_perr), .mabort_req(mabort_req),
    .det_perr(det_perr), .sig_serr(sig_serr)
  );

  logic [DW-1:0] h_ad [HN];
  logic [BW-1:0] h_cbe [HN];
  bit h_par [HN], h_frm [HN], h_irdy [HN], h_trdy [HN];
  bit h_mst [HN], h_rd [HN], h_pe [HN], h_se [HN], h_clr [HN];

  int cyc = 0, total = 0, bad_n = 0;
  bit done = 0, pend_par = 0;
  bit v_pe = 0, v_se = 0, v_mst = 0, v_rd = 0, v_clr = 0;
  bit m_det = 0, m_sig = 0;
  string tag = "reset";

  function automatic bit is_addr(int k);
    if (k < 0) return 0;
    return !h_frm[k] && (k == 0 ? 1'b1 : h_frm[k-1]);
  endfunction
  function automatic bit is_data(int k);
    if (k < 0) return 0;
    return !h_irdy[k] && !h_trdy[k] && !is_addr(k);
  endfunction
  function automatic bit bus_bad(int k);
    return (^{h_ad[k], h_cbe[k]}) ^ h_par[k+1];
  endfunction
  function automatic bit aerr(int c);
    return c >= 1 && is_addr(c-1) && bus_bad(c-1);
  endfunction
  function automatic bit derr(int c);
    return c >= 1 && is_data(c-1) && bus_bad(c-1);
  endfunction
  function automatic bit serr_go(int c);
    return c >= 0 && aerr(c) && h_pe[c] && h_se[c];
  endfunction
  function automatic bit perr_go(int c);
    return c >= 1 && derr(c) && h_pe[c] && (h_mst[c-1] == h_rd[c-1]);
  endfunction

  task automatic chk(input bit act, input bit exp, input string sig, input string req);
    total++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s [%s] %s: actual=%0b expected=%0b cycle=%0d", req, tag, sig, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit slo, slo1, plo, plo1;
    slo  = cyc >= 1 && serr_go(cyc-1);
    slo1 = cyc >= 2 && serr_go(cyc-2);
    plo  = cyc >= 1 && perr_go(cyc-1);
    plo1 = cyc >= 2 && perr_go(cyc-2);
    if (cyc >= 1) begin
      if (aerr(cyc-1) || derr(cyc-1)) m_det = 1;
      else if (h_clr[cyc-1]) m_det = 0;
      if (serr_go(cyc-1)) m_sig = 1;
      else if (h_clr[cyc-1]) m_sig = 0;
    end
    chk(addr_perr, aerr(cyc), "addr_perr", "R1");
    chk(mabort_req, derr(cyc) && h_mst[cyc-1] && h_rd[cyc-1], "mabort_req", "R7");
    chk(serr_n_o, !slo, "serr_n_o", "R3");
    chk(serr_oe, slo || slo1, "serr_oe", "R4");
    chk(perr_n_o, !plo, "perr_n_o", "R5");
    chk(perr_oe, plo || plo1, "perr_oe", "R4");
    chk(det_perr, m_det, "det_perr", "R9");
    chk(sig_serr, m_sig, "sig_serr", "R9");
  endtask

  task automatic step(input bit frm, input bit ir, input bit tr,
                      input logic [DW-1:0] a, input logic [BW-1:0] be, input bit corrupt);
    @(negedge clk);
    frame_n = frm; irdy_n = ir; trdy_n = tr; ad = a; cbe_n = be; par = pend_par;
    is_master = v_mst; is_read = v_rd; cmd_perr_en = v_pe; cmd_serr_en = v_se;
    flag_clr = v_clr; v_clr = 0;
    pend_par = (^{a, be}) ^ corrupt;
    h_ad[cyc] = a; h_cbe[cyc] = be; h_par[cyc] = par; h_frm[cyc] = frm;
    h_irdy[cyc] = ir; h_trdy[cyc] = tr; h_mst[cyc] = is_master; h_rd[cyc] = is_read;
    h_pe[cyc] = cmd_perr_en; h_se[cyc] = cmd_serr_en; h_clr[cyc] = flag_clr;
    #2;
    compare();
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 32'h0, 4'hF, 0);
  endtask

  task automatic txn(input bit mst, input bit rd, input bit abad, input int n,
                     input bit [7:0] dbad, input bit [7:0] dwait);
    v_mst = mst; v_rd = rd;
    step(0, 1, 1, 32'h1000_0040 + 32'(cyc * 4), {3'b011, rd}, abad);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      d = 32'hA5C3_0000 ^ 32'(i * 32'h1357) ^ 32'(cyc);
      if (dwait[i]) step(i == n-1, 0, 1, d ^ 32'h0F0F, 4'(i), 1);
      step(i == n-1, 0, 0, d, 4'(i + 3), dbad[i]);
    end
    v_mst = 0; v_rd = 0;
    step(1, 1, 1, 32'h0, 4'hF, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad_n++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(serr_oe, 0, "serr_oe", "R10"); chk(perr_oe, 0, "perr_oe", "R10");
    chk(serr_n_o, 1, "serr_n_o", "R10"); chk(perr_n_o, 1, "perr_n_o", "R10");
    chk(det_perr, 0, "det_perr", "R10"); chk(sig_serr, 0, "sig_serr", "R10");
    chk(addr_perr, 0, "addr_perr", "R10"); chk(mabort_req, 0, "mabort_req", "R10");
    rst_n = 1;
    v_pe = 1; v_se = 1;
    tag = "R1 clean target write";       txn(0, 0, 0, 2, 8'h00, 8'h00); idle(3);
    tag = "R3 address error reported";   txn(0, 0, 1, 1, 8'h00, 8'h00); idle(4);
    tag = "R9 clear alone";              v_clr = 1; idle(3);
    tag = "R3 serr gated off";           v_se = 0; txn(0, 0, 1, 1, 8'h00, 8'h00); idle(4); v_se = 1;
    tag = "R5 target write data error";  txn(0, 0, 0, 2, 8'h01, 8'h00); idle(4);
    tag = "R6 target read not reported"; txn(0, 1, 0, 2, 8'h02, 8'h00); idle(4);
    tag = "R7 master read data error";   txn(1, 1, 0, 2, 8'h01, 8'h00); idle(4);
    tag = "R6 master write not reported";txn(1, 0, 0, 2, 8'h03, 8'h00); idle(4);
    tag = "R2 wait states bad parity";   v_clr = 1; idle(1); txn(0, 0, 0, 3, 8'h00, 8'h05); idle(4);
    tag = "R8 back-to-back data errors"; txn(0, 0, 0, 4, 8'h06, 8'h00); idle(4);
    tag = "R5 parity response off";      v_pe = 0; txn(1, 1, 0, 2, 8'h01, 8'h00); idle(4); v_pe = 1;
    tag = "R4 address then data error";  txn(0, 0, 1, 2, 8'h01, 8'h00); idle(5);
    tag = "R9 set wins over clear";      v_clr = 1; idle(2);
    v_mst = 0; v_rd = 0;
    step(0, 1, 1, 32'h2000_0000, 4'h7, 0);
    step(1, 0, 0, 32'hDEAD_BEEF, 4'h0, 1);
    v_clr = 1; step(1, 1, 1, 32'h0, 4'hF, 0);
    idle(4);
    tag = "R1 byte-enable parity";       txn(0, 0, 0, 3, 8'h00, 8'h00); idle(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end
endmodule